// File: doc/BRIEF.md
# Multi-Lane Pixel Steering Packer

This block takes a byte-wide stream of pixel symbols, framed by a per-line active flag, and spreads it over one, two or four link lanes in a fixed round-robin order. Pixels are gathered into lane-wide groups and held in a small group queue. A packer emits the groups into fixed-length transfer units that all lanes frame in lockstep. Each unit starts with data symbols and then switches to stuffing. The stuffing run opens with a fill-start control symbol and closes with a fill-end control symbol in the unit's last slot.

The number of data slots in each unit is a programmed fill count, so the data-to-stuffing ratio follows the ratio of pixel rate to link rate that software computes elsewhere. When the queue runs dry before the fill count is reached, the unit switches to stuffing early and keeps its length. When the active flag drops, the queue drains. A blanking-start control symbol then goes out on every active lane in the same cycle, and the lanes go idle. Each lane carries one byte plus a control flag per cycle. Lane mode, unit length and fill count are captured when a line opens.

Top module: `lane_packer`

## Requirements
- R1: Lane mode encoding on `cfg_lanes`: 00 selects 1 lane, 01 selects 2 lanes, 10 or 11 selects 4 lanes. With N lanes, pixel k of a line is sent on lane k mod N, and each lane carries its pixels in arrival order.
- R2: Steering restarts at lane 0 with the first pixel of every line. If a line's pixel count is not a multiple of N, the last group is completed with 00h data symbols (flag 0) on the remaining lanes.
- R3: Lanes at index N and above output 00h with the control flag at 0 in every cycle.
- R4: The transfer unit length is `cfg_tu_len` clamped to the range 32..64. Every unit not cut short by end of line ends with a fill-end symbol (F7h, flag 1) on all active lanes in its last slot.
- R5: Within a unit, all data symbols (flag 0) come first. They are followed by one fill-start symbol (FEh, flag 1), then stuffing symbols (00h, flag 0) up to the fill-end. The number of data symbols per unit never exceeds the fill count, which is `cfg_fill` clamped to 1..(length-2).
- R6: While queued data is always available, every complete unit carries exactly the fill count of data symbols.
- R7: When the queue is empty at a data slot, the unit switches to fill-start at that slot. The fill-end still lands in the unit's last slot.
- R8: After the active flag drops and all data of the line has been emitted, one blanking-start symbol (BCh, flag 1) appears on every active lane in the same cycle. It cuts the current unit, and all lanes are idle in the next cycle.
- R9: Lane mode, unit length and fill count are captured when a line opens. Changes to them during the line have no effect on that line.
- R10: A pixel is taken only in a cycle where `in_valid` and `in_ready` are both high. No pixel is lost or repeated under stalls or backpressure.
- R11: During and right after reset, all lane outputs are zero and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lanes | input | 2 | Lane mode, captured at line open |
| cfg_tu_len | input | 7 | Transfer unit length, clamped to 32..64 |
| cfg_fill | input | 7 | Data slots per unit, clamped to 1..length-2 |
| in_active | input | 1 | High for the duration of an active line |
| in_valid | input | 1 | Pixel present on `in_pix` |
| in_pix | input | 8 | Pixel symbol |
| in_ready | output | 1 | Block can take a pixel this cycle |
| out_sym | output | 32 | Lane symbols, lane i at bits 8i+7..8i |
| out_k | output | 4 | Control flag per lane |

## Verification
The hardest case to reach from the ports is a data slot that finds the group queue empty while the line is still open. This is the early switch to stuffing. It only happens when the pixel supply falls behind the lane rate after the queue has been drained. The bench reaches it in two ways. One uses four lanes fed at one pixel per cycle, so a group completes only every fourth cycle. The other uses one lane, where the driver drops `in_valid` for long stretches during a line. The bench parses every cycle of every lane against the unit framing. It also checks that, for each lane, the sequence of data symbols matches the round-robin split of the pixels that were sent.

// File: rtl/lane_packer.sv
module lane_packer #(
  parameter int SYM_W  = 8,
  parameter int NLANE  = 4,
  parameter int DEPTH  = 4,
  parameter int TU_MIN = 32,
  parameter int TU_MAX = 64,
  parameter logic [SYM_W-1:0] K_BS = SYM_W'('hBC),
  parameter logic [SYM_W-1:0] K_FS = SYM_W'('hFE),
  parameter logic [SYM_W-1:0] K_FE = SYM_W'('hF7),
  localparam int TW = $clog2(TU_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_lanes,
  input  logic [TW-1:0]          cfg_tu_len,
  input  logic [TW-1:0]          cfg_fill,
  input  logic                   in_active,
  input  logic                   in_valid,
  input  logic [SYM_W-1:0]       in_pix,
  output logic                   in_ready,
  output logic [NLANE*SYM_W-1:0] out_sym,
  output logic [NLANE-1:0]       out_k
);
  localparam int GW = NLANE * SYM_W;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic          line_open, draining, running, stuffing;
  logic [1:0]    mode_q;
  logic [TW-1:0] len_q, fill_q, pos;
  logic [LW-1:0] gcnt, last_slot;
  logic [GW-1:0] gbuf, gnext, wdata, rdata;
  logic [GW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  logic [TW-1:0] len_c, fill_c;
  assign len_c  = (cfg_tu_len < TW'(TU_MIN)) ? TW'(TU_MIN) :
                  (cfg_tu_len > TW'(TU_MAX)) ? TW'(TU_MAX) : cfg_tu_len;
  assign fill_c = (cfg_fill == '0) ? TW'(1) :
                  (cfg_fill > len_c - TW'(2)) ? len_c - TW'(2) : cfg_fill;

  always_comb begin
    case (mode_q)
      2'd0:    last_slot = '0;
      2'd1:    last_slot = LW'(1);
      default: last_slot = LW'(NLANE - 1);
    endcase
  end

  logic start, full, acc, push_full, push_flush, push, pop, bs, go, at_end;
  assign start      = in_active && !line_open && !draining;
  assign full       = (cnt == CW'(DEPTH));
  assign in_ready   = in_active && line_open && ((gcnt != last_slot) || !full);
  assign acc        = in_valid && in_ready;
  assign push_full  = acc && (gcnt == last_slot);
  assign push_flush = draining && (gcnt != '0) && !full;
  assign push       = push_full || push_flush;
  assign wdata      = push_full ? gnext : gbuf;
  assign bs         = draining && (gcnt == '0) && (cnt == '0);
  assign go         = running || (cnt != '0);
  assign at_end     = (pos == len_q - TW'(1));
  assign pop        = go && !bs && !at_end && !stuffing && (pos < fill_q) && (cnt != '0);
  assign rdata      = mem[rp];

  always_comb begin
    gnext = gbuf;
    gnext[gcnt*SYM_W +: SYM_W] = in_pix;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  logic [GW-1:0]    nsym;
  logic [NLANE-1:0] nk;
  always_comb begin
    nsym = '0;
    nk   = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (LW'(i) <= last_slot) begin
        if (bs) begin
          nsym[i*SYM_W +: SYM_W] = K_BS;
          nk[i] = 1'b1;
        end else if (go) begin
          if (at_end) begin
            nsym[i*SYM_W +: SYM_W] = K_FE;
            nk[i] = 1'b1;
          end else if (pop) begin
            nsym[i*SYM_W +: SYM_W] = rdata[i*SYM_W +: SYM_W];
          end else if (!stuffing) begin
            nsym[i*SYM_W +: SYM_W] = K_FS;
            nk[i] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_open <= 1'b0;
      draining  <= 1'b0;
      running   <= 1'b0;
      stuffing  <= 1'b0;
      mode_q    <= 2'd0;
      len_q     <= TW'(TU_MIN);
      fill_q    <= TW'(1);
      pos       <= '0;
      gcnt      <= '0;
      gbuf      <= '0;
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      out_sym   <= '0;
      out_k     <= '0;
    end else begin
      out_sym <= nsym;
      out_k   <= nk;

      if (start) begin
        line_open <= 1'b1;
        mode_q    <= cfg_lanes;
        len_q     <= len_c;
        fill_q    <= fill_c;
      end else if (line_open && !in_active) begin
        line_open <= 1'b0;
        draining  <= 1'b1;
      end

      if (push) begin
        gbuf <= '0;
        gcnt <= '0;
        wp   <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      end else if (acc) begin
        gbuf <= gnext;
        gcnt <= gcnt + LW'(1);
      end

      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);

      if (bs) begin
        draining <= 1'b0;
        running  <= 1'b0;
        stuffing <= 1'b0;
        pos      <= '0;
      end else if (go) begin
        running <= 1'b1;
        if (at_end) begin
          pos      <= '0;
          stuffing <= 1'b0;
        end else begin
          pos <= pos + TW'(1);
          if (!pop && !stuffing) stuffing <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lane_packer_chk.sv
module lane_packer_chk #(
  parameter int SYM_W = 8,
  parameter int NLANE = 4,
  parameter int DEPTH = 4,
  parameter logic [SYM_W-1:0] K_BS = SYM_W'('hBC),
  parameter logic [SYM_W-1:0] K_FS = SYM_W'('hFE)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NLANE*SYM_W-1:0]      out_sym,
  input logic [NLANE-1:0]            out_k,
  input logic [1:0]                  mode_q,
  input logic [$clog2(DEPTH+1)-1:0]  fifo_cnt
);
  localparam int GW = NLANE * SYM_W;

  AST_LANE1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_k[1] || out_sym[2*SYM_W-1:SYM_W] != '0) |-> ($past(mode_q) != 2'd0)); // R3

  AST_TOP_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_k[NLANE-1] || out_sym[GW-1 -: SYM_W] != '0) |-> ($past(mode_q) >= 2'd2)); // R3

  AST_BS_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_k[0] && out_sym[SYM_W-1:0] == K_BS && $past(mode_q) != 2'd0)
      |-> (out_k[1] && out_sym[2*SYM_W-1:SYM_W] == K_BS)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R10

  AST_NO_DATA_AFTER_FS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_k[0] && out_sym[SYM_W-1:0] == K_FS) |=> (out_k[0] || out_sym[SYM_W-1:0] == '0)); // R5
endmodule

bind lane_packer lane_packer_chk #(
  .SYM_W(SYM_W), .NLANE(NLANE), .DEPTH(DEPTH), .K_BS(K_BS), .K_FS(K_FS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_sym(out_sym), .out_k(out_k),
  .mode_q(mode_q), .fifo_cnt(cnt)
);

// File: tb/lane_packer_tb.sv
`timescale 1ns/1ps
module lane_packer_tb;
  localparam logic [7:0] BS = 8'hBC, FS = 8'hFE, FE = 8'hF7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_lanes = '0;
  logic [6:0] cfg_tu_len = 7'd32, cfg_fill = 7'd8;
  logic in_active = 1'b0, in_valid = 1'b0, in_ready;
  logic [7:0] in_pix = '0;
  logic [31:0] out_sym;
  logic [3:0] out_k;

  lane_packer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_lanes(cfg_lanes), .cfg_tu_len(cfg_tu_len),
    .cfg_fill(cfg_fill), .in_active(in_active), .in_valid(in_valid), .in_pix(in_pix),
    .in_ready(in_ready), .out_sym(out_sym), .out_k(out_k)
  );

  always #2 clk = ~clk;

  int total = 0, fail = 0;
  int e_st, e_fe, e_idle, e_bs, full_tus, min_d, max_d, data_err, to;
  int gc [4];
  logic [7:0] got [4][512];

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pv(int k, int s);
    return 8'(((k * 37 + s * 11) % 251) + 1);
  endfunction

  function automatic bit busy0();
    return out_k[0] || out_sym[7:0] != 8'h00;
  endfunction

  task automatic drive(int mode, int len, int fill, int npix, int seed, bit stall, bit chg);
    int k = 0, last_stall = -1;
    bit r;
    @(negedge clk);
    cfg_lanes = 2'(mode); cfg_tu_len = 7'(len); cfg_fill = 7'(fill);
    in_active = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    while (k < npix) begin
      if (stall && k % 8 == 7 && last_stall != k) begin
        last_stall = k;
        in_valid = 1'b0;
        repeat (12) @(negedge clk);
      end
      in_valid = 1'b1; in_pix = pv(k, seed);
      #1 r = in_ready;
      @(negedge clk);
      if (r) k++;
      if (chg && k == 2) begin cfg_lanes = 2'd0; cfg_tu_len = 7'd60; cfg_fill = 7'd3; end
    end
    in_valid = 1'b0; in_active = 1'b0;
  endtask

  task automatic monitor(int n, int L, int F);
    int pos = 0, dc = 0, cyc = 0;
    bit st = 0, done = 0;
    e_st = 0; e_fe = 0; e_idle = 0; e_bs = 0; full_tus = 0; min_d = 999; max_d = -1; to = 0;
    for (int i = 0; i < 4; i++) gc[i] = 0;
    do begin @(negedge clk); cyc++; end while (!busy0() && cyc < 4000);
    if (cyc >= 4000) to = 1;
    while (!done && !to) begin
      for (int i = n; i < 4; i++) if (out_k[i] || out_sym[i*8 +: 8] != 0) e_idle++;
      if (out_k[0] && out_sym[7:0] == BS) begin
        for (int i = 0; i < n; i++) if (!(out_k[i] && out_sym[i*8 +: 8] == BS)) e_bs++;
        done = 1;
      end else if (pos == L - 1) begin
        for (int i = 0; i < n; i++) if (!(out_k[i] && out_sym[i*8 +: 8] == FE)) e_fe++;
        full_tus++;
        if (dc < min_d) min_d = dc;
        if (dc > max_d) max_d = dc;
        pos = 0; dc = 0; st = 0;
      end else begin
        if (!st) begin
          if (out_k[0]) begin
            for (int i = 0; i < n; i++) if (!(out_k[i] && out_sym[i*8 +: 8] == FS)) e_st++;
            st = 1;
          end else begin
            for (int i = 0; i < n; i++) begin
              if (out_k[i]) e_st++;
              if (gc[i] < 512) got[i][gc[i]] = out_sym[i*8 +: 8];
              gc[i]++;
            end
            dc++;
            if (dc > F) e_st++;
          end
        end else begin
          for (int i = 0; i < n; i++) if (out_k[i] || out_sym[i*8 +: 8] != 0) e_st++;
        end
        pos++;
      end
      if (!done) begin
        @(negedge clk); cyc++;
        if (cyc > 8000) to = 1;
      end
    end
    if (done) begin
      @(negedge clk);
      if (out_k != 4'h0 || out_sym != 32'h0) e_bs++;
    end
  endtask

  task automatic run_line(int mode, int len, int fill, int npix, int seed, bit stall, bit chg);
    int n = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
    int L = (len < 32) ? 32 : (len > 64) ? 64 : len;
    int F = (fill == 0) ? 1 : (fill > L - 2) ? L - 2 : fill;
    int G = (npix + n - 1) / n;
    fork
      drive(mode, len, fill, npix, seed, stall, chg);
      monitor(n, L, F);
    join
    data_err = 0;
    for (int i = 0; i < n; i++) begin
      if (gc[i] != G) data_err++;
      else for (int g = 0; g < G; g++) begin
        logic [7:0] e = (g * n + i < npix) ? pv(g * n + i, seed) : 8'h00;
        if (got[i][g] != e) data_err++;
      end
    end
    check(to == 0, "R8", "line completed with blanking-start", to, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(out_sym == 32'h0 && out_k == 4'h0, "R11", "lane outputs in reset", int'(out_k), 0);
    check(in_ready == 1'b0, "R11", "in_ready after reset", int'(in_ready), 0);
  endtask

  task automatic t_one_lane_exact();
    run_line(0, 40, 30, 100, 1, 0, 0);
    check(data_err == 0, "R1", "1-lane data order", data_err, 0);
    check(full_tus == 3 && e_fe == 0, "R4", "1-lane full units / fill-end", full_tus, 3);
    check(min_d == 30 && max_d == 30, "R6", "data per unit", min_d, 30);
    check(e_st == 0, "R5", "unit structure errors", e_st, 0);
    check(e_idle == 0, "R3", "idle lanes in 1-lane mode", e_idle, 0);
    check(e_bs == 0, "R8", "blanking-start and idle after", e_bs, 0);
  endtask

  task automatic t_four_lane_early();
    run_line(2, 32, 20, 64, 2, 0, 0);
    check(data_err == 0, "R1", "4-lane steering", data_err, 0);
    check(full_tus >= 1 && min_d < 20, "R7", "early switch to stuffing", min_d, 19);
    check(e_fe == 0 && e_st == 0, "R7", "unit length kept with early switch", e_fe + e_st, 0);
    check(e_bs == 0, "R8", "blanking-start on 4 lanes", e_bs, 0);
  endtask

  task automatic t_two_lane_pad();
    run_line(1, 36, 12, 37, 3, 0, 0);
    check(data_err == 0, "R2", "2-lane steering with padded last group", data_err, 0);
    check(e_idle == 0, "R3", "lanes 2,3 idle in 2-lane mode", e_idle, 0);
    check(e_bs == 0 && e_st == 0, "R8", "2-lane line end", e_bs + e_st, 0);
  endtask

  task automatic t_restart();
    run_line(2, 40, 16, 6, 4, 0, 0);
    check(data_err == 0, "R2", "first line of 6 pixels", data_err, 0);
    run_line(2, 40, 16, 9, 5, 0, 0);
    check(data_err == 0, "R2", "second line restarts at lane 0", data_err, 0);
  endtask

  task automatic t_clamp_low();
    run_line(0, 10, 0, 12, 6, 0, 0);
    check(full_tus == 11 && e_fe == 0, "R4", "length clamped to 32", full_tus, 11);
    check(min_d == 1 && max_d == 1, "R5", "fill clamped to 1", max_d, 1);
  endtask

  task automatic t_clamp_high();
    run_line(0, 100, 70, 140, 7, 0, 0);
    check(full_tus == 2 && e_fe == 0, "R4", "length clamped to 64", full_tus, 2);
    check(min_d == 62 && max_d == 62, "R6", "fill clamped to length-2", min_d, 62);
    check(data_err == 0, "R1", "long 1-lane line", data_err, 0);
  endtask

  task automatic t_mid_change();
    run_line(2, 40, 10, 40, 8, 0, 1);
    check(data_err == 0, "R9", "lane mode change mid-line ignored", data_err, 0);
    check(e_fe == 0 && e_st == 0, "R9", "unit settings change mid-line ignored", e_fe + e_st, 0);
  endtask

  task automatic t_stall();
    run_line(0, 32, 24, 60, 9, 1, 0);
    check(data_err == 0, "R10", "no loss under stalls", data_err, 0);
    check(full_tus >= 1 && min_d < 24, "R7", "early switch on stalled input", min_d, 23);
    check(e_fe == 0 && e_st == 0, "R5", "framing under stalls", e_fe + e_st, 0);
  endtask

  task automatic t_empty_line();
    run_line(2, 32, 8, 0, 10, 0, 0);
    check(e_bs == 0 && gc[0] == 0, "R8", "empty line gives lone blanking-start", e_bs + gc[0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_lane_exact();
    t_four_lane_early();
    t_two_lane_pad();
    t_restart();
    t_clamp_low();
    t_clamp_high();
    t_mid_change();
    t_stall();
    t_empty_line();
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  end
endmodule